// File: doc/BRIEF.md
# Pulse-Pause Reader Frame Transmitter

This block sends a short frame from a reader to a tag by switching an RF carrier enable on and off. A frame opens with a charging interval: the carrier stays on long enough for the tag to power up. Each data bit then starts with a carrier-off gap of fixed length. The carrier comes back on, and the total length of the bit carries its value: a long bit is a one and a short bit is a zero. After the last bit, one more gap closes the frame. At that point the block emits a one-cycle pulse that re-zeroes a shared timer, so the receive path can measure the tag's reply from the end of the frame. The carrier then stays on through a response window and is switched off, which lets the tag reset.

All durations are counted in ticks of a shared timebase, given as a clock enable. A cycle without a tick does not advance any interval. Software starts a frame by presenting up to 16 data bits and a bit count with a one-cycle start strobe.

Top module: `pp_frame_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `carrier_on` is 0 and `frame_done` is 0.
- R2: A `start` strobe seen while idle, with `tx_bits` not zero, raises `busy` on the next cycle. The carrier is then held on for CHARGE_TICKS ticks (1500 by default, which is 1 ms at a 0.667 µs tick).
- R3: Every data bit begins with the carrier off for PAUSE_TICKS ticks (30 by default).
- R4: Bits go out starting at `tx_data[0]`. A bit whose value is 1 lasts ONE_TICKS ticks in total (150), measured from the start of its pause. A bit whose value is 0 lasts ZERO_TICKS ticks in total (90). Exactly the requested number of bits is sent.
- R5: A `tx_bits` of 0 starts nothing: `busy` and `carrier_on` stay low. A `tx_bits` above 16 sends 16 bits.
- R6: After the last data bit, the carrier goes off for one more PAUSE_TICKS gap and then comes back on.
- R7: `frame_done` is high for exactly one cycle per frame. That cycle is the first one in which the carrier is back on after the closing gap. `frame_done` is low at all other times.
- R8: After the closing gap, the carrier stays on for RESP_TICKS ticks (1000 by default). It then turns off, and `busy` falls in the same cycle.
- R9: A `start` strobe that arrives while `busy` is high has no effect on the frame in progress.
- R10: Only cycles with `tick_en` high advance any interval. The edge that accepts `start` does not count toward the charging interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable from the shared timebase |
| start | input | 1 | Start strobe for a frame |
| tx_data | input | 16 | Frame bits, bit 0 sent first |
| tx_bits | input | 5 | Number of bits to send (0 = none, above 16 = 16) |
| carrier_on | output | 1 | RF carrier enable |
| busy | output | 1 | High from frame acceptance until the response window ends |
| frame_done | output | 1 | One-cycle pulse that re-zeroes the shared receive timer |

## Verification
The hardest situation to reach is a start strobe that lands in the very first idle cycle after a frame, or in the middle of a busy frame, while ticks arrive irregularly. This matters because the phase counter must neither absorb stray ticks nor reload its data. The bench measures each carrier run in ticks rather than cycles. It drives the tick enable in three patterns: every cycle, every third cycle, and at random. It injects a second strobe with different data part-way through one frame. It then restarts on the first idle cycle after that frame finishes. Every run must still match the queued expectation exactly.

// File: rtl/pp_tx_pkg.sv
// Package: shared state encoding and carrier decode for the pulse-pause
// transmitter. Assumes a single clock domain.
package pp_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHARGE = 3'd1,
        ST_PAUSE  = 3'd2,
        ST_MARK   = 3'd3,
        ST_EOF    = 3'd4,
        ST_LISTEN = 3'd5
    } tx_state_e;

    // Carrier level that belongs to each phase.
    function automatic logic carrier_level(input tx_state_e s);
        return (s == ST_CHARGE) || (s == ST_MARK) || (s == ST_LISTEN);
    endfunction

endpackage

// File: rtl/pp_phase_timer.sv
// Phase timer: counts timebase ticks inside the current phase.
// expire is high on the tick that completes 'limit' ticks, and the counter
// wraps to zero on that tick. While 'hold' is high the counter stays at zero.
// Assumes limit >= 1 and that limit changes only on an expire or while held.
module pp_phase_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;

    // Terminal-tick detect for the current phase.
    always_comb begin
        expire = !hold && tick_en && (cnt_q == limit - 1'b1);
    end

    // Tick counter with wrap on expire.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (cnt_q < limit)); // R10

endmodule

// File: rtl/pp_bit_shifter.sv
// Bit shifter: on load, captures the frame word and a bit count clamped to
// DATA_W. On each shift it moves the word one place toward bit 0.
// cur_bit is the bit being sent. last_bit is high while one bit remains.
// Assumes shift is issued only while bits remain.
module pp_bit_shifter #(
    parameter int DATA_W = 16,
    parameter int BITS_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] load_data,
    input  logic [BITS_W-1:0] load_bits,
    output logic              cur_bit,
    output logic              last_bit
);

    localparam logic [BITS_W-1:0] MAX_BITS = BITS_W'(DATA_W);

    logic [DATA_W-1:0] word_q;
    logic [BITS_W-1:0] remain_q;
    logic [BITS_W-1:0] clamped;

    // Limit the requested count to the word width.
    always_comb begin
        clamped = (load_bits > MAX_BITS) ? MAX_BITS : load_bits;
    end

    // Word and remaining-bit count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            remain_q <= '0;
        end else if (load) begin
            word_q   <= load_data;
            remain_q <= clamped;
        end else if (shift) begin
            word_q   <= word_q >> 1;
            remain_q <= remain_q - 1'b1;
        end
    end

    // Present the head bit and last-bit flag.
    always_comb begin
        cur_bit  = word_q[0];
        last_bit = (remain_q == BITS_W'(1));
    end

    AST_SHIFT_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> (remain_q != '0)); // R4

    AST_COUNT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (remain_q <= MAX_BITS)); // R5

endmodule

// File: rtl/pp_tx_fsm.sv
// Frame sequencer: walks charge, per-bit pause and mark, closing gap and
// response window. It selects the tick limit of each phase and drives the
// carrier, busy and done outputs. Assumes the phase timer wraps on expire.
module pp_tx_fsm
    import pp_tx_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int PAUSE_T  = 30,
    parameter int MARK1_T  = 120,
    parameter int MARK0_T  = 60,
    parameter int CHARGE_T = 1500,
    parameter int RESP_T   = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start,
    input  logic             bits_nonzero,
    input  logic             expire,
    input  logic             cur_bit,
    input  logic             last_bit,
    output logic [CNT_W-1:0] limit,
    output logic             timer_hold,
    output logic             load,
    output logic             shift,
    output logic             carrier,
    output logic             busy,
    output logic             done
);

    tx_state_e state_q, state_d;
    logic      done_q;

    // Next-state logic and shifter/timer control.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        shift   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start && bits_nonzero) begin
                    state_d = ST_CHARGE;
                    load    = 1'b1;
                end
            end
            ST_CHARGE: if (expire) state_d = ST_PAUSE;
            ST_PAUSE:  if (expire) state_d = ST_MARK;
            ST_MARK: begin
                if (expire) begin
                    shift   = 1'b1;
                    state_d = last_bit ? ST_EOF : ST_PAUSE;
                end
            end
            ST_EOF:    if (expire) state_d = ST_LISTEN;
            ST_LISTEN: if (expire) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Tick limit for the phase in progress.
    always_comb begin
        unique case (state_q)
            ST_CHARGE: limit = CNT_W'(CHARGE_T);
            ST_MARK:   limit = cur_bit ? CNT_W'(MARK1_T) : CNT_W'(MARK0_T);
            ST_LISTEN: limit = CNT_W'(RESP_T);
            default:   limit = CNT_W'(PAUSE_T);
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // One-cycle frame-done pulse when the closing gap ends.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_EOF) && expire;
    end

    // Output decode.
    always_comb begin
        timer_hold = (state_q == ST_IDLE);
        carrier    = carrier_level(state_q);
        busy       = (state_q != ST_IDLE);
        done       = done_q;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!carrier && !done)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AT_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (carrier && !$past(carrier))); // R7

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_CHARGE) |=> (state_q != ST_CHARGE)); // R9

    AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && state_q != ST_IDLE) |=> (state_q == $past(state_q))); // R10

    AST_WINDOW_ENDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LISTEN && expire) |=> (!carrier && !busy)); // R8

endmodule

// File: rtl/pp_frame_tx.sv
// Pulse-pause frame transmitter top. It connects the sequencer, the phase
// timer and the bit shifter. Assumes tick_en is a one-cycle enable
// synchronous to clk and that the tick lengths fit the derived counter width.
module pp_frame_tx #(
    parameter int DATA_W       = 16,
    parameter int BITS_W       = $clog2(DATA_W + 1),
    parameter int PAUSE_TICKS  = 30,
    parameter int ONE_TICKS    = 150,
    parameter int ZERO_TICKS   = 90,
    parameter int CHARGE_TICKS = 1500,
    parameter int RESP_TICKS   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [BITS_W-1:0] tx_bits,
    output logic              carrier_on,
    output logic              busy,
    output logic              frame_done
);

    localparam int MARK1_T = ONE_TICKS - PAUSE_TICKS;
    localparam int MARK0_T = ZERO_TICKS - PAUSE_TICKS;
    localparam int MAX_A   = (CHARGE_TICKS > RESP_TICKS) ? CHARGE_TICKS : RESP_TICKS;
    localparam int MAX_T   = (MAX_A > ONE_TICKS) ? MAX_A : ONE_TICKS;
    localparam int CNT_W   = $clog2(MAX_T + 1);

    logic             expire;
    logic             timer_hold;
    logic [CNT_W-1:0] limit;
    logic             load;
    logic             shift;
    logic             cur_bit;
    logic             last_bit;
    logic             bits_nonzero;

    // A zero count requests no frame.
    always_comb begin
        bits_nonzero = (tx_bits != '0);
    end

    pp_tx_fsm #(
        .CNT_W    (CNT_W),
        .PAUSE_T  (PAUSE_TICKS),
        .MARK1_T  (MARK1_T),
        .MARK0_T  (MARK0_T),
        .CHARGE_T (CHARGE_TICKS),
        .RESP_T   (RESP_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .start        (start),
        .bits_nonzero (bits_nonzero),
        .expire       (expire),
        .cur_bit      (cur_bit),
        .last_bit     (last_bit),
        .limit        (limit),
        .timer_hold   (timer_hold),
        .load         (load),
        .shift        (shift),
        .carrier      (carrier_on),
        .busy         (busy),
        .done         (frame_done)
    );

    pp_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (timer_hold),
        .tick_en (tick_en),
        .limit   (limit),
        .expire  (expire)
    );

    pp_bit_shifter #(
        .DATA_W (DATA_W),
        .BITS_W (BITS_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift     (shift),
        .load_data (tx_data),
        .load_bits (tx_bits),
        .cur_bit   (cur_bit),
        .last_bit  (last_bit)
    );

endmodule

// File: tb/pp_frame_tx_tb.sv
// Scoreboard bench: the driver queues the expected carrier runs (level and
// length in ticks). The monitor measures each run and compares it.
module pp_frame_tx_tb;

    localparam int PAUSE = 30;
    localparam int ONE   = 150;
    localparam int ZERO  = 90;
    localparam int CHG   = 1500;
    localparam int RESP  = 1000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        start;
    logic [15:0] tx_data;
    logic [4:0]  tx_bits;
    logic        carrier_on;
    logic        busy;
    logic        frame_done;

    int vectors = 0;
    int errors  = 0;
    int tick_mode = 0;
    int phase3 = 0;
    bit finished = 0;

    bit    exp_lvl[$];
    int    exp_len[$];
    bit    exp_done[$];
    string exp_req[$];

    always #2.5 clk = ~clk;

    pp_frame_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .start      (start),
        .tx_data    (tx_data),
        .tx_bits    (tx_bits),
        .carrier_on (carrier_on),
        .busy       (busy),
        .frame_done (frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input bit lvl, input int len, input bit dn, input string req);
        exp_lvl.push_back(lvl);
        exp_len.push_back(len);
        exp_done.push_back(dn);
        exp_req.push_back(req);
    endtask

    // Monitor: measures runs in ticks and drives the next tick enable.
    bit lvl = 0;
    bit run_busy = 0;
    int run_cnt = 0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (carrier_on != lvl) begin
                int len;
                len = run_cnt + (tick_en ? 1 : 0);
                if (run_busy) begin
                    if (exp_len.size() == 0) begin
                        check(0, "R9 unexpected run", len, 0);
                    end else begin
                        bit    el;
                        int    en;
                        bit    ed;
                        string er;
                        el = exp_lvl.pop_front();
                        en = exp_len.pop_front();
                        ed = exp_done.pop_front();
                        er = exp_req.pop_front();
                        check(el == lvl, {er, " run level"}, lvl, el);
                        check(en == len, {er, " run ticks"}, len, en);
                        check(frame_done == ed, "R7 done at run end", frame_done, ed);
                        if (er == "R8") check(busy == 1'b0, "R8 busy falls", busy, 0);
                    end
                end
                lvl = carrier_on;
                run_cnt = 0;
                run_busy = busy;
            end else begin
                run_cnt += tick_en ? 1 : 0;
                if (frame_done) check(0, "R7 stray done", 1, 0);
            end
            if (!busy && (carrier_on || frame_done))
                check(0, "R1 idle quiet", {carrier_on, frame_done}, 0);
        end
        case (tick_mode)
            0: tick_en = 1'b1;
            1: begin phase3 = (phase3 + 1) % 3; tick_en = (phase3 == 0); end
            default: tick_en = 1'($urandom_range(0, 1));
        endcase
    end

    task automatic send_frame(input logic [15:0] d, input int n, input int mode, input bit poke);
        int eff;
        eff = (n > 16) ? 16 : n;
        @(negedge clk);
        tick_mode = mode;
        push(1, CHG, 0, "R2");
        for (int i = 0; i < eff; i++) begin
            push(0, PAUSE, 0, "R3");
            push(1, d[i] ? ONE - PAUSE : ZERO - PAUSE, 0, "R4");
        end
        push(0, PAUSE, 1, "R6");
        push(1, RESP, 0, "R8");
        start = 1'b1; tx_data = d; tx_bits = 5'(n);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy rises", busy, 1);
        if (poke) begin
            repeat (700) @(negedge clk);
            start = 1'b1; tx_data = ~d; tx_bits = 5'd3;   // R9 strobe while busy
            @(negedge clk);
            start = 1'b0;
            repeat (2000) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; tx_data = '0; tx_bits = '0; tick_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!carrier_on && !busy && !frame_done, "R1 reset state",
              {carrier_on, busy, frame_done}, 0);

        send_frame(16'hA5C3, 16, 0, 0);      // R4 mixed bits, full length
        send_frame(16'h0001, 1, 1, 0);       // R10 sparse ticks, single one
        send_frame(16'h0000, 3, 2, 0);       // R10 random ticks, zeros

        @(negedge clk);                      // R5 zero count starts nothing
        start = 1'b1; tx_data = 16'hFFFF; tx_bits = 5'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check(!busy && !carrier_on, "R5 zero count ignored", {busy, carrier_on}, 0);

        send_frame(16'hFFFF, 20, 0, 0);      // R5 count above 16 clamps
        send_frame(16'h00F0, 9, 0, 1);       // R9 strobes while busy
        tick_mode = 2;
        send_frame(16'h5A3C, 14, 2, 0);      // R2 restart on first idle cycle

        repeat (10) @(negedge clk);
        check(exp_len.size() == 0, "R6 all runs seen", exp_len.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule